// File: doc/BRIEF.md
# Trace packet width-adaptive serializer

This block takes one trace packet at a time and sends it out over a narrow port whose width is chosen at run time. A packet is a 24-bit header followed by 8, 16, 32 or 64 data bits, depending on the access size. Packets arrive over a valid/ready interface as a size code and a packed, MSB-aligned bit vector. The block then drives the packet out as a run of subpackets, one per clock, most significant bit first.

A frame strobe marks the first subpacket of each packet. If the last subpacket is not fully used, its trailing bits are driven as zeros. The port width code is read only when a packet is accepted. The next packet can be accepted during the last subpacket of the current one, so packets follow each other with no idle cycle between them.

Top module: `tp_serializer`

## Requirements
- R1: While in reset and just after it: out_valid_o=0, out_frame_o=0, out_data_o=0 and in_ready_o=1.
- R2: The packet length comes from in_size_i: code 0 gives 32 bits, 1 gives 40, 2 gives 56 and 3 gives 88. The packet occupies in_pkt_i[87 downto 88-length], and any lower bits of in_pkt_i are ignored.
- R3: The port width comes from width_i: code 0 gives 2 lines, 1 gives 4, 2 gives 8 and 3 gives 16. An accepted packet keeps out_valid_o high for exactly ceil(length/width) consecutive cycles, starting the cycle after acceptance.
- R4: Subpacket k places packet bit in_pkt_i[87-k*W-j] on out_data_o[W-1-j], so the most significant bit goes first.
- R5: In the last subpacket, the positions that lie past the end of the packet are driven as 0.
- R6: When the width is below 16, out_data_o bits W and above are 0.
- R7: out_frame_o is high on the first subpacket of each packet and low on every other cycle.
- R8: in_ready_o is high when the block is idle or on the last subpacket of a packet, and low otherwise.
- R9: width_i is sampled only in the cycle a packet is accepted. Changes to it during a packet have no effect on that packet.
- R10: A packet accepted during the last subpacket of the previous one starts on the very next cycle, with no idle cycle between them.
- R11: While out_valid_o is low, out_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_i | input | 2 | Port width code (0:2, 1:4, 2:8, 3:16 lines) |
| in_valid_i | input | 1 | A packet is offered |
| in_ready_o | output | 1 | A packet can be accepted this cycle |
| in_size_i | input | 2 | Access size code (0:8, 1:16, 2:32, 3:64 data bits) |
| in_pkt_i | input | 88 | Packet bits, MSB-aligned |
| out_valid_o | output | 1 | A subpacket is on out_data_o |
| out_frame_o | output | 1 | The first subpacket of a packet |
| out_data_o | output | 16 | Subpacket data, right-aligned within the port |

## Verification
A packet that is accepted at a clock edge produces its first subpacket on the outputs right after that edge. Each following subpacket appears one edge later. in_ready_o is a combinational function of the current state, so it is valid throughout the cycle. The bench drives inputs and compares all outputs at the falling edge, against a queue of the beats it expects. The reference pushes the beats of an accepted packet behind the beat now showing, so each beat is compared in exactly the cycle it is due. The bench changes width_i randomly on every cycle in which no packet is accepted. This checks that the width is taken only at acceptance.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} size_e;
  typedef enum logic [1:0] {PW_2 = 2'd0, PW_4 = 2'd1, PW_8 = 2'd2, PW_16 = 2'd3} width_e;
endpackage

// File: rtl/tp_beat_calc.sv
module tp_beat_calc
  import tp_pkg::*;
#(
  parameter int HDR_W  = 24,
  parameter int DMIN_W = 8,
  parameter int PMIN_W = 2,
  parameter int LEN_W  = 7
) (
  input  size_e              size_i,
  input  width_e             width_i,
  output logic [LEN_W-1:0]   len_o,
  output logic [LEN_W-1:0]   beats_o
);
  localparam int PMIN_SH = $clog2(PMIN_W);

  logic [LEN_W:0] rnd_up;

  // R2: header plus data of DMIN_W << size
  assign len_o   = LEN_W'(HDR_W) + (LEN_W'(DMIN_W) << size_i);
  // ceil(len / width), with the width a power of two
  assign rnd_up  = {1'b0, len_o} + (((LEN_W+1)'(PMIN_W)) << width_i) - (LEN_W+1)'(1);
  assign beats_o = LEN_W'(rnd_up >> (PMIN_SH + int'(width_i)));
endmodule

// File: rtl/tp_shifter.sv
module tp_shifter
  import tp_pkg::*;
#(
  parameter int PKT_W  = 88,
  parameter int OUT_W  = 16,
  parameter int PMIN_W = 2,
  parameter int NW     = 4,
  parameter int LEN_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic [LEN_W-1:0] len_i,
  input  width_e           width_i,
  output logic [OUT_W-1:0] data_o
);
  logic [PKT_W-1:0] sreg_q;
  logic [PKT_W-1:0] keep_mask;
  width_e           width_q;
  logic [OUT_W-1:0] lane [NW];

  // keep the top len_i bits only; the rest become padding zeros
  assign keep_mask = ~({PKT_W{1'b1}} >> len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      width_q <= PW_2;
    end else if (load_i) begin
      sreg_q  <= pkt_i & keep_mask;
      width_q <= width_i;
    end else if (shift_i) begin
      sreg_q  <= sreg_q << (PMIN_W << width_q);
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_lane
    assign lane[k] = OUT_W'(sreg_q[PKT_W-1 -: (PMIN_W << k)]);
  end

  assign data_o = lane[width_q];

  // R9: the width in use holds for the whole packet
  a_r9_width_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> $stable(width_q));

  // R6: lines above the active width stay low
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(data_o) >> (PMIN_W << width_q)) == 32'd0);
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [CNT_W-1:0] beats_i,
  output logic             ready_o,
  output logic             load_o,
  output logic             busy_o,
  output logic             frame_o,
  output logic             last_o
);
  logic             busy_q, first_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_o  = busy_q && (cnt_q == '0);
  assign ready_o = !busy_q || last_o;
  assign load_o  = in_valid_i && ready_o;
  assign busy_o  = busy_q;
  assign frame_o = busy_q && first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      first_q <= 1'b1;
      cnt_q   <= beats_i - CNT_W'(1);
    end else if (busy_q) begin
      first_q <= 1'b0;
      if (last_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // R10: a packet taken on the last beat starts next cycle
  a_r10_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && in_valid_i) |=> (busy_o && frame_o));

  // R3: a packet's beats are contiguous
  a_r3_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (busy_o && !frame_o));

  // R7: every packet has at least two beats, so frames never repeat
  a_r7_single_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);
endmodule

// File: rtl/tp_serializer.sv
module tp_serializer
  import tp_pkg::*;
#(
  parameter int HDR_W  = 24,
  parameter int DMIN_W = 8,
  parameter int PMIN_W = 2,
  parameter int NW     = 4,
  localparam int PKT_W = HDR_W + (DMIN_W << (NW - 1)),
  localparam int OUT_W = PMIN_W << (NW - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       width_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       in_size_i,
  input  logic [PKT_W-1:0] in_pkt_i,
  output logic             out_valid_o,
  output logic             out_frame_o,
  output logic [OUT_W-1:0] out_data_o
);
  localparam int LEN_W = $clog2(PKT_W + 1);

  logic [LEN_W-1:0] len, beats;
  logic             load, busy, last;

  tp_beat_calc #(.HDR_W(HDR_W), .DMIN_W(DMIN_W), .PMIN_W(PMIN_W), .LEN_W(LEN_W)) calc_i (
    .size_i  (size_e'(in_size_i)),
    .width_i (width_e'(width_i)),
    .len_o   (len),
    .beats_o (beats)
  );

  tp_ctrl #(.CNT_W(LEN_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .beats_i    (beats),
    .ready_o    (in_ready_o),
    .load_o     (load),
    .busy_o     (busy),
    .frame_o    (out_frame_o),
    .last_o     (last)
  );

  tp_shifter #(.PKT_W(PKT_W), .OUT_W(OUT_W), .PMIN_W(PMIN_W), .NW(NW), .LEN_W(LEN_W)) shift_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (busy),
    .pkt_i   (in_pkt_i),
    .len_i   (len),
    .width_i (width_e'(width_i)),
    .data_o  (out_data_o)
  );

  assign out_valid_o = busy;

  // R11: the register drains to zero by the end of every packet
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_data_o == '0));

  // R8: the input is closed in the middle of a packet
  a_r8_ready_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !last) |-> !in_ready_o);
endmodule

// File: tb/tp_serializer_tb_top.sv
module tp_serializer_tb_top;
  localparam int PKT_W = 88;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       width_i = '0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [1:0]       in_size_i = '0;
  logic [PKT_W-1:0] in_pkt_i = '0;
  logic             out_valid_o, out_frame_o;
  logic [OUT_W-1:0] out_data_o;

  always #4 clk = ~clk;  // 125 MHz

  tp_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .width_i(width_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_size_i(in_size_i), .in_pkt_i(in_pkt_i),
    .out_valid_o(out_valid_o), .out_frame_o(out_frame_o), .out_data_o(out_data_o)
  );

  typedef struct {
    logic        frame;
    logic [15:0] data;
    int          w;
    logic        pad;
  } beat_t;

  beat_t q[$];
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  bit prev_valid = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R2, R3, R4, R5: expected beats of one packet, built bit by bit
  task automatic push_pkt(input logic [1:0] sz, input logic [1:0] wc, input logic [PKT_W-1:0] p);
    int len, w, n;
    len = 24 + (8 << sz);
    w   = 2 << wc;
    n   = (len + w - 1) / w;
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.frame = (k == 0);
      b.data  = '0;
      b.w     = w;
      b.pad   = ((k + 1) * w > len);
      for (int j = 0; j < w; j++)
        if (k * w + j < len) b.data[w-1-j] = p[PKT_W-1-(k*w+j)];
      q.push_back(b);
    end
  endtask

  function automatic logic [PKT_W-1:0] rnd_pkt();
    return PKT_W'({$urandom, $urandom, $urandom});
  endfunction

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    int          idx = 0;
    int          n_dir = 16;
    int          n_all = 16 + 300;
    logic [1:0]  p_sz, p_wc;
    logic [PKT_W-1:0] p_pkt;
    bit          exp_ready;
    bit          gap;

    // R1: reset state
    @(negedge clk);
    chk(out_valid_o == 0, "R1", 32'(out_valid_o), 0);
    chk(out_frame_o == 0, "R1", 32'(out_frame_o), 0);
    chk(out_data_o == 0, "R1", 32'(out_data_o), 0);
    chk(in_ready_o == 1, "R1", 32'(in_ready_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;

    p_sz  = 2'($urandom);
    p_wc  = 2'($urandom);
    p_pkt = rnd_pkt();

    while (idx < n_all || q.size() > 0) begin
      @(negedge clk);
      exp_ready = (q.size() <= 1);
      chk(in_ready_o == exp_ready, "R8", 32'(in_ready_o), 32'(exp_ready));
      chk(out_valid_o == (q.size() > 0), "R3/R9", 32'(out_valid_o), 32'(q.size() > 0));
      if (q.size() > 0) begin
        beat_t b;
        logic [15:0] wm;
        b  = q.pop_front();
        wm = 16'((32'd1 << b.w) - 1);
        chk(out_frame_o == b.frame, (b.frame && prev_valid) ? "R10" : "R7",
            32'(out_frame_o), 32'(b.frame));
        chk((out_data_o & ~wm) == 0, "R6", 32'(out_data_o & ~wm), 0);
        chk((out_data_o & wm) == b.data, b.pad ? "R5" : "R2/R4",
            32'(out_data_o & wm), 32'(b.data));
        prev_valid = 1;
      end else begin
        chk(out_frame_o == 0, "R7", 32'(out_frame_o), 0);
        chk(out_data_o == 0, "R11", 32'(out_data_o), 0);
        prev_valid = 0;
      end

      // next packet: the first 16 sweep every size/width pair back to back
      if (idx < n_dir) begin
        p_sz = 2'(idx % 4);
        p_wc = 2'(idx / 4);
        gap  = 0;
      end else begin
        gap = (($urandom % 4) == 0);
      end
      if (idx < n_all && !gap) begin
        in_valid_i = 1'b1;
        in_size_i  = p_sz;
        in_pkt_i   = p_pkt;  // low garbage beyond the length checks R2
        // R9: the width only counts in the acceptance cycle
        width_i    = exp_ready ? p_wc : 2'($urandom);
        if (exp_ready) begin
          push_pkt(p_sz, p_wc, p_pkt);
          idx++;
          p_sz  = 2'($urandom);
          p_wc  = 2'($urandom);
          p_pkt = rnd_pkt();
        end
      end else begin
        in_valid_i = 1'b0;
        in_size_i  = 2'($urandom);
        in_pkt_i   = rnd_pkt();
        width_i    = 2'($urandom);
      end
    end

    @(negedge clk);
    chk(out_valid_o == 0, "R11", 32'(out_valid_o), 0);
    chk(out_data_o == 0, "R11", 32'(out_data_o), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule